// File: doc/BRIEF.md
# Programmable Pin Output and Input Cell

This block sits between a bank of macrocells and their chip pins. On the output side, each macrocell value passes through a programmable inversion and leaves as a pin value together with a separate tri-state enable. That enable comes from one of three places: the macrocell's own output-enable product term, one of two global fast output-enable lines, or both together. A permanent-disable option keeps the pins undriven whatever the enable sources do.

On the input side, the pin value passes through its own programmable inversion and goes back toward the interconnect. It can go back directly, or through a capture flip-flop. That flip-flop loads only when the selected one of two clock-enable lines is high. The whole bank shares one configuration word. The pin count is a parameter. All registers run on a single fast clock and reset low.

Top module: `pin_io_cell`

## Requirements
- R1: `padOut` equals `mcValue` when `cfgOutInvert` is 0 and equals its bitwise inverse when `cfgOutInvert` is 1, in the same cycle.
- R2: With `cfgOeSel` = 2'b00 and `cfgOutDisable` = 0, each bit of `padOe` follows the matching bit of `oePterm`.
- R3: With `cfgOeSel` = 2'b01 and `cfgOutDisable` = 0, every bit of `padOe` equals `fastOe[cfgFastSel]`.
- R4: With `cfgOeSel` = 2'b10 and `cfgOutDisable` = 0, each bit of `padOe` is the AND of its `oePterm` bit and `fastOe[cfgFastSel]`.
- R5: With `cfgOeSel` = 2'b11 and `cfgOutDisable` = 0, every bit of `padOe` is 1.
- R6: `cfgOutDisable` = 1 forces every bit of `padOe` to 0, overriding all enable sources and selections.
- R7: With `cfgInRegistered` = 0, `inToMatrix` equals `padIn` XOR `cfgInInvert` in the same cycle.
- R8: With `cfgInRegistered` = 1, `inToMatrix` shows the capture register. At a rising clock edge where `cken[cfgCkenSel]` is 1, the register loads `padIn` XOR `cfgInInvert`. When that enable is 0, the register holds its value.
- R9: While `rstN` is low, the capture register is cleared, so `inToMatrix` reads all zeros in registered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the input capture register |
| rstN | input | 1 | Active-low asynchronous reset |
| mcValue | input | PINS | Macrocell output values |
| oePterm | input | PINS | Per-macrocell output-enable product terms |
| fastOe | input | 2 | Global fast output-enable lines |
| cfgOutInvert | input | 1 | Invert the outgoing pin value |
| cfgOutDisable | input | 1 | Permanently disable the output buffers |
| cfgOeSel | input | 2 | Enable source: 00 private, 01 fast, 10 both, 11 always |
| cfgFastSel | input | 1 | Which fast enable line is used |
| cfgInInvert | input | 1 | Invert the incoming pin value |
| cfgInRegistered | input | 1 | Route the input through the capture register |
| cfgCkenSel | input | 1 | Which clock-enable line gates the capture |
| cken | input | 2 | Clock-enable lines |
| padIn | input | PINS | Values seen at the pins |
| padOut | output | PINS | Values driven toward the pins |
| padOe | output | PINS | Tri-state enables, 1 = drive |
| inToMatrix | output | PINS | Input path toward the interconnect |

## Verification
The bench goes after the points where enable sources meet. These are disable asserted while "always enabled" is selected, the AND mode with only one side active, and the unused fast line toggling while the other is selected. A design that let the select override the disable would drive the pins. A design that ORed the enables would drive when only one side was active. A design that looked at the wrong fast line would follow noise. On the input side, the bench toggles both clock-enable lines independently. A register gated by the wrong enable, or loading the value before inversion, would show a stale or inverted capture one cycle later.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;
  typedef enum logic [1:0] {
    OE_PRIVATE = 2'b00,
    OE_FAST    = 2'b01,
    OE_BOTH    = 2'b10,
    OE_ALWAYS  = 2'b11
  } oeSel_e;

  typedef struct packed {
    logic outInvert;
    logic inInvert;
    logic captureEn;
    logic useReg;
  } ioStrobes_t;
endpackage

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
  import pin_io_pkg::*;
#(
  parameter int PINS = 4
) (
  input  logic [PINS-1:0] oePterm,
  input  logic [1:0]      fastOe,
  input  logic            cfgOutInvert,
  input  logic            cfgOutDisable,
  input  logic [1:0]      cfgOeSel,
  input  logic            cfgFastSel,
  input  logic            cfgInInvert,
  input  logic            cfgInRegistered,
  input  logic            cfgCkenSel,
  input  logic [1:0]      cken,
  output logic [PINS-1:0] oeVec,
  output ioStrobes_t      strobes
);
  logic           fastPick;
  logic [PINS-1:0] fastVec;
  logic [PINS-1:0] rawOe;
  oeSel_e          sel;

  assign sel      = oeSel_e'(cfgOeSel);
  assign fastPick = fastOe[cfgFastSel];
  assign fastVec  = {PINS{fastPick}};

  always_comb begin
    unique case (sel)
      OE_PRIVATE: rawOe = oePterm;
      OE_FAST:    rawOe = fastVec;
      OE_BOTH:    rawOe = oePterm & fastVec;
      default:    rawOe = '1;
    endcase
  end

  assign oeVec = cfgOutDisable ? '0 : rawOe;

  assign strobes.outInvert = cfgOutInvert;
  assign strobes.inInvert  = cfgInInvert;
  assign strobes.captureEn = cken[cfgCkenSel];
  assign strobes.useReg    = cfgInRegistered;

  always_comb begin
    if (!cfgOutDisable && sel == OE_ALWAYS)
      assert_always_on_R5: assert (&oeVec);
    if (!cfgOutDisable && sel == OE_BOTH)
      assert_both_needs_fast_R4: assert (fastPick || oeVec == '0);
  end
endmodule

// File: rtl/pin_io_datapath.sv
module pin_io_datapath
  import pin_io_pkg::*;
#(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ioStrobes_t      strobes,
  input  logic [PINS-1:0] mcValue,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] inToMatrix
);
  logic [PINS-1:0] inAdj;
  logic [PINS-1:0] capReg;

  for (genvar i = 0; i < PINS; i++) begin : gPin
    assign padOut[i] = mcValue[i] ^ strobes.outInvert;
    assign inAdj[i]  = padIn[i] ^ strobes.inInvert;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  capReg[i] <= 1'b0;
      else if (strobes.captureEn) capReg[i] <= inAdj[i];
    end

    assign inToMatrix[i] = strobes.useReg ? capReg[i] : inAdj[i];
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureEn |=> $stable(capReg));
  assert_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureEn |=> capReg == $past(padIn ^ {PINS{strobes.inInvert}}));
  always_comb begin
    if (!rstN) assert_reset_clear_R9: assert (capReg == '0);
  end
endmodule

// File: rtl/pin_io_cell.sv
module pin_io_cell
  import pin_io_pkg::*;
#(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] mcValue,
  input  logic [PINS-1:0] oePterm,
  input  logic [1:0]      fastOe,
  input  logic            cfgOutInvert,
  input  logic            cfgOutDisable,
  input  logic [1:0]      cfgOeSel,
  input  logic            cfgFastSel,
  input  logic            cfgInInvert,
  input  logic            cfgInRegistered,
  input  logic            cfgCkenSel,
  input  logic [1:0]      cken,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] inToMatrix
);
  ioStrobes_t strobes;

  pin_io_ctrl #(.PINS(PINS)) u_ctrl (
    .oePterm(oePterm), .fastOe(fastOe),
    .cfgOutInvert(cfgOutInvert), .cfgOutDisable(cfgOutDisable),
    .cfgOeSel(cfgOeSel), .cfgFastSel(cfgFastSel),
    .cfgInInvert(cfgInInvert), .cfgInRegistered(cfgInRegistered),
    .cfgCkenSel(cfgCkenSel), .cken(cken),
    .oeVec(padOe), .strobes(strobes)
  );

  pin_io_datapath #(.PINS(PINS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .mcValue(mcValue), .padIn(padIn),
    .padOut(padOut), .inToMatrix(inToMatrix)
  );

  always_comb begin
    if (cfgOutDisable) assert_disable_wins_R6: assert (padOe == '0);
  end
endmodule

// File: tb/pin_io_cell_bench.sv
module pin_io_cell_bench;
  localparam int PINS = 4;

  logic clk = 0, rstN = 0;
  logic [PINS-1:0] mcValue = '0, oePterm = '0, padIn = '0;
  logic [1:0] fastOe = '0, cfgOeSel = '0, cken = '0;
  logic cfgOutInvert = 0, cfgOutDisable = 0, cfgFastSel = 0;
  logic cfgInInvert = 0, cfgInRegistered = 0, cfgCkenSel = 0;
  logic [PINS-1:0] padOut, padOe, inToMatrix;

  int checks = 0, errors = 0;
  logic [PINS-1:0] modelReg = '0;
  bit done = 0;

  pin_io_cell #(.PINS(PINS)) u_pin_io_cell (.*);

  always #10 clk = ~clk;

  // Reference capture register, updated behaviourally on each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelReg <= '0;
    else if (cken[cfgCkenSel]) modelReg <= padIn ^ {PINS{cfgInInvert}};
  end

  task automatic check(string tag, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [PINS-1:0] expOe();
    logic f = fastOe[cfgFastSel];
    logic [PINS-1:0] e;
    if (cfgOutDisable) return '0;
    for (int i = 0; i < PINS; i++) begin
      case (cfgOeSel)
        2'b00: e[i] = oePterm[i];
        2'b01: e[i] = f;
        2'b10: e[i] = oePterm[i] && f;
        default: e[i] = 1'b1;
      endcase
    end
    return e;
  endfunction

  function automatic string oeTag();
    if (cfgOutDisable) return "R6";
    case (cfgOeSel)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R1 padOut", padOut, mcValue ^ {PINS{cfgOutInvert}});
      check({oeTag(), " padOe"}, padOe, expOe());
      if (cfgInRegistered) check("R8 inToMatrix", inToMatrix, modelReg);
      else check("R7 inToMatrix", inToMatrix, padIn ^ {PINS{cfgInInvert}});
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    fork
      begin
        cfgInRegistered = 1;
        padIn = 4'b1011;
        cken = 2'b11;
        step(2);
        #5 check("R9 reset clears capture", inToMatrix, '0);
        rstN = 1;
        step(1);
        // R8: capture gated by the selected enable only
        cken = 2'b10; cfgCkenSel = 0; padIn = 4'b0110; step(1);
        cken = 2'b01; padIn = 4'b1001; step(2);
        cfgCkenSel = 1; cken = 2'b01; padIn = 4'b0011; step(2);
        cken = 2'b10; cfgInInvert = 1; step(2);
        // R6 beats always-on and active sources
        cfgOeSel = 2'b11; cfgOutDisable = 1; oePterm = '1; fastOe = 2'b11; step(2);
        cfgOutDisable = 0; step(1);
        // R4 with only one side active; R3 with the unused line toggling
        cfgOeSel = 2'b10; fastOe = 2'b01; cfgFastSel = 1; step(1);
        cfgFastSel = 0; oePterm = 4'b0101; step(1);
        cfgOeSel = 2'b01; cfgFastSel = 1; fastOe = 2'b01; step(1);
        fastOe = 2'b10; step(1);
        // Random sweep over every mode
        for (int k = 0; k < 400; k++) begin
          {mcValue, oePterm, padIn} = 12'($urandom);
          {fastOe, cken, cfgOeSel} = 6'($urandom);
          {cfgOutInvert, cfgOutDisable, cfgFastSel, cfgInInvert,
           cfgInRegistered, cfgCkenSel} = 6'($urandom);
          step(1);
        end
        step(1);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule